// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns the system clock into a single-cycle enable pulse at sixteen times a UART bit rate. Software programs a 16-bit whole-cycle divisor and a 6-bit fractional divisor in units of 1/64 cycle. The intended values are the system clock divided by sixteen times the bit rate: the whole part is the integer quotient, and the fraction is the remainder scaled by 64 and rounded. Each divisor has its own register on a simple write and read port.

The fraction is applied by dithering. A 6-bit accumulator gains the fraction once per tick. Each tick period whose addition carries out of the accumulator is one clock longer. Over every run of 64 periods, exactly as many periods are stretched as the fraction says, so the mean period is (whole × 64 + fraction) / 64 clocks.

Register writes only update pending copies of the divisors. A separate latch strobe copies both pending values into the running divisors at the same clock edge, restarts the period count and clears the accumulator. The generator therefore never runs on a half-written divisor. A whole divisor of zero is treated as invalid and stops the ticks.

Top module: `baud_frac_gen`

## Requirements
- R1: While and after reset, and before any write, the tick is low, the accumulator is clear, and both divisor registers read 0.
- R2: The whole divisor sits at byte address 0x024, in bits 15:0. The fraction sits at byte address 0x028, in bits 5:0. A write at any other address changes nothing, and a read at any other address returns 0.
- R3: A read returns the pending value last written, with all unused upper bits zero. Bits 31:6 of a fraction write are dropped.
- R4: Writing either divisor without a latch strobe leaves the tick pattern unchanged.
- R5: A latch strobe loads both pending values at one edge, forces the tick low at that edge, clears the accumulator, and starts a new period. The first tick after the strobe edge appears after a number of clock edges equal to the whole divisor.
- R6: When the whole divisor is 2 or more, each tick is high for exactly one clock cycle.
- R7: A running whole divisor of zero produces no ticks.
- R8: Period k lasts W + c clocks, where W is the whole divisor and c is the carry out of acc + F (F is the fraction). After each tick, acc becomes (acc + F) mod 64. The accumulator starts at 0 after a latch strobe.
- R9: Starting from a latch strobe, the 64th tick arrives exactly 64 × W + F clocks after the strobe edge.
- R10: The full whole-divisor range works: W = 0xFFFF gives a first period of 65535 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write enable, sampled on the rising clock edge |
| addr_i | input | 12 | Byte address for write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| load_i | input | 1 | Latch strobe that moves the pending divisors into the running ones |
| tick_o | output | 1 | Registered 16x oversampling enable pulse |

## Verification
The bench sweeps every fraction value for whole divisors 1, 2 and 3, and compares the tick with an arithmetic model on every cycle. A design that put the stretch in the wrong period, or that updated the accumulator before the stretch decision, would fail on a single cycle. A design that lost carries would miss the 64-period total. A whole divisor of 1 makes the tick stay high across periods, and a wrong stretch shows up there as a missing low cycle. A zero divisor must stay silent rather than wrap its counter. A write without a strobe must leave the old rate running, and the largest divisor must not overflow the period counter. The register tests check address decode, fraction masking and readback of unused bits.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_WHOLE = 2'd1,
    SEL_FRAC  = 2'd2
  } bfg_sel_e;

endpackage

// File: rtl/bfg_regs.sv
module bfg_regs #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] WHOLE_ADDR = 12'h024,
  parameter logic [ADDR_W-1:0] FRAC_ADDR  = 12'h028
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load,
  output logic [DATA_W-1:0] rdata,
  output logic [INT_W-1:0]  whole_act,
  output logic [FRAC_W-1:0] frac_act
);
  import baud_pkg::*;

  logic [INT_W-1:0]  whole_pend;
  logic [FRAC_W-1:0] frac_pend;
  bfg_sel_e          sel;

  function automatic bfg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == WHOLE_ADDR)     return SEL_WHOLE;
    else if (a == FRAC_ADDR) return SEL_FRAC;
    else                     return SEL_NONE;
  endfunction

  assign sel = decode(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      whole_pend <= '0;
      frac_pend  <= '0;
    end else if (wr_en) begin
      if (sel == SEL_WHOLE) whole_pend <= wdata[INT_W-1:0];
      if (sel == SEL_FRAC)  frac_pend  <= wdata[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      whole_act <= '0;
      frac_act  <= '0;
    end else if (load) begin
      whole_act <= whole_pend;
      frac_act  <= frac_pend;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_WHOLE: rdata = DATA_W'(whole_pend);
      SEL_FRAC:  rdata = DATA_W'(frac_pend);
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/bfg_dither.sv
module bfg_dither #(
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              period_end,
  input  logic [FRAC_W-1:0] frac,
  output logic [FRAC_W-1:0] acc,
  output logic              stretch
);

  logic [FRAC_W:0] sum;

  function automatic logic [FRAC_W:0] frac_add(input logic [FRAC_W-1:0] a,
                                              input logic [FRAC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum     = frac_add(acc, frac);
  assign stretch = sum[FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc <= '0;
    else if (load)       acc <= '0;
    else if (period_end) acc <= sum[FRAC_W-1:0];
  end

endmodule

// File: rtl/bfg_counter.sv
module bfg_counter #(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [INT_W-1:0] whole,
  input  logic             stretch,
  output logic             period_end,
  output logic             tick
);
  localparam int CW = INT_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          run;

  function automatic logic [CW-1:0] last_count(input logic [INT_W-1:0] w,
                                              input logic             s);
    return {1'b0, w} + CW'(s) - CW'(1);
  endfunction

  assign run        = (whole != '0);
  assign last       = last_count(whole, stretch);
  assign period_end = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load || !run)     cnt <= '0;
    else if (period_end)       cnt <= '0;
    else                       cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tick <= 1'b0;
    else if (load) tick <= 1'b0;
    else           tick <= period_end;
  end

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] WHOLE_ADDR = 12'h024,
  parameter logic [ADDR_W-1:0] FRAC_ADDR  = 12'h028
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              load_i,
  output logic              tick_o
);

  logic [INT_W-1:0]  whole_act_w;
  logic [FRAC_W-1:0] frac_act_w;
  logic [FRAC_W-1:0] acc_w;
  logic              stretch_w;
  logic              period_end_w;

  bfg_regs #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WHOLE_ADDR(WHOLE_ADDR), .FRAC_ADDR(FRAC_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i),
    .wdata(wdata_i), .load(load_i), .rdata(rdata_o),
    .whole_act(whole_act_w), .frac_act(frac_act_w)
  );

  bfg_dither #(.FRAC_W(FRAC_W)) u_dither (
    .clk(clk), .rst_n(rst_n), .load(load_i), .period_end(period_end_w),
    .frac(frac_act_w), .acc(acc_w), .stretch(stretch_w)
  );

  bfg_counter #(.INT_W(INT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .load(load_i), .whole(whole_act_w),
    .stretch(stretch_w), .period_end(period_end_w), .tick(tick_o)
  );

endmodule

// File: rtl/bfg_checker.sv
module bfg_checker #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              tick,
  input logic [INT_W-1:0]  whole_act,
  input logic [FRAC_W-1:0] frac_act,
  input logic [FRAC_W-1:0] acc,
  input logic              stretch
);

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!tick && acc == '0 && whole_act == '0); // R1
    end
  end

  AST_LATCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(whole_act) && $stable(frac_act))); // R4

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc == '0 && !tick)); // R5

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && whole_act > INT_W'(1)) |=> !tick); // R6

  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (whole_act == '0 && !load) |=> !tick); // R7

  AST_NO_FRAC_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_act == '0) |-> !stretch); // R8

endmodule

bind baud_frac_gen bfg_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load_i), .tick(tick_o),
  .whole_act(whole_act_w), .frac_act(frac_act_w), .acc(acc_w),
  .stretch(stretch_w)
);

// File: tb/baud_frac_gen_test.sv
module baud_frac_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        load_i = 1'b0;
  logic        tick_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model state
  int unsigned p_w = 0, p_f = 0;          // pending
  int unsigned a_w = 0, a_f = 0;          // running
  int unsigned m_acc = 0, m_rem = 0;

  baud_frac_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .load_i(load_i), .tick_o(tick_o)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (a == 12'h024) p_w = d & 32'hFFFF;
    if (a == 12'h028) p_f = d & 32'h3F;
  endtask

  task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr_i = a;
    #1;
    check(rdata_o == exp, req, rdata_o, exp);
  endtask

  task automatic latch();
    @(negedge clk);
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    a_w = p_w; a_f = p_f; m_acc = 0; m_rem = a_w;
    check(tick_o == 1'b0, "R5 tick low after strobe", tick_o, 0);
  endtask

  // advance one cycle, return expected tick
  task automatic step(output bit exp);
    @(negedge clk);
    exp = 1'b0;
    if (a_w != 0) begin
      m_rem--;
      if (m_rem == 0) begin
        exp = 1'b1;
        m_acc = (m_acc + a_f) % 64;
        m_rem = a_w + (((m_acc + a_f) >= 64) ? 1 : 0);
      end
    end
  endtask

  task automatic run(input int n, input string req);
    bit e;
    for (int i = 0; i < n; i++) begin
      step(e);
      check(tick_o == e, req, tick_o, e);
    end
  endtask

  task automatic sweep_one(input int unsigned w, input int unsigned f);
    bit e;
    int cyc = 0;
    int ticks = 0;
    int bad = 0;
    wr(12'h024, w);
    wr(12'h028, f);
    latch();
    while (ticks < 64 && cyc < 20000) begin
      step(e);
      cyc++;
      if (tick_o !== e) bad++;
      if (e) ticks++;
    end
    check(bad == 0, "R8 per-cycle dither pattern", bad, 0);
    check(cyc == 64 * w + f, "R9 64-period total", cyc, 64 * w + f);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tick_o == 1'b0, "R1 tick low in reset", tick_o, 0);
    rst_n = 1'b1;
    rd_check(12'h024, 32'h0, "R1 whole reads 0");
    rd_check(12'h028, 32'h0, "R1 fraction reads 0");
    run(20, "R1 no tick after reset");

    // register map and readback
    wr(12'h024, 32'hABCD_1234);
    rd_check(12'h024, 32'h0000_1234, "R3 whole readback");
    wr(12'h028, 32'hFFFF_FFFF);
    rd_check(12'h028, 32'h0000_003F, "R3 fraction masked");
    wr(12'h02C, 32'h0000_0007);
    wr(12'h020, 32'h0000_0009);
    rd_check(12'h024, 32'h0000_1234, "R2 unmapped write ignored");
    rd_check(12'h028, 32'h0000_003F, "R2 unmapped write ignored");
    rd_check(12'h02C, 32'h0, "R2 unmapped read 0");
    rd_check(12'h000, 32'h0, "R2 unmapped read 0");
    run(10, "R4 no tick before strobe");

    // zero divisor
    wr(12'h024, 0);
    wr(12'h028, 5);
    latch();
    run(200, "R7 zero divisor silent");

    // pending write does not disturb running rate
    wr(12'h024, 4);
    wr(12'h028, 0);
    latch();
    run(12, "R5 first tick after strobe");
    wr(12'h024, 2);
    wr(12'h028, 40);
    run(40, "R4 old rate kept");
    latch();
    run(60, "R5 new rate after strobe");
    run(30, "R6 single-cycle pulse");

    // sweep
    for (int w = 1; w <= 3; w++)
      for (int f = 0; f < 64; f++)
        sweep_one(w, f);

    // full range
    wr(12'h024, 32'hFFFF);
    wr(12'h028, 1);
    latch();
    run(65540, "R10 max divisor first period");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule